// File: doc/BRIEF.md
# Execution-Unit Register File with Packed-Address Command Bus

This block is one slice of an execution-unit datapath. It holds a 32-bit register store and is steered by a single 32-bit command word on every clock. That word carries three 8-bit register addresses: two read ports, A and B, and one write destination, C. The two read words are captured and combined by an OR-type ALU. The result then sits in an output stage. From there it can be placed on a memory data bus, written back into the store under a C address given in a later command, or sent to a front-end bus when the destination falls in a small high window of addresses.

A front-end sequencer loads a constant into a register in four steps. First it raises the immediate-select input one cycle ahead. Next it places the constant itself on the command bus, where it is ORed with a zero left operand. It then issues one idle command. Finally it names the destination in the C field. A reject input from the memory side freezes the whole pipeline. A nonzero fault code sets a sticky exception flag. All pipeline state moves on the rising edge of one clock, and reset is synchronous and active high.

Top module: `eu_regpipe`

## Requirements
- R1: The command word is decoded as A read address in bits 7:0, B read address in bits 15:8 and C write address in bits 23:16. Bits 31:24 have no effect on a command that is not an immediate.
- R2: Both read ports are used on every cycle. A command issued in cycle N with `to_mem` high drives `mem_oe` high in cycle N+2, with `mem_data` equal to reg[A] OR reg[B].
- R3: Addresses 1 to 127 are general registers. A C address given in cycle M stores the output-stage value seen in cycle M, and a read issued in cycle M+1 or later returns it.
- R4: Address 0 always reads as zero and ignores writes. Address 128 is the discard destination, and every address from 128 to 239 discards writes and reads as zero. A write to an address in that range leaves the general registers unchanged.
- R5: A C address in the range 240 to 255 does not change any general register. In the next cycle only, it drives `fe_oe` high with `fe_data` equal to the output-stage value and `fe_sel` equal to C minus 240. Reading any of these addresses returns zero.
- R6: The `imm_next` input is registered. When it is high in cycle N-1, the word of cycle N is an immediate: the left operand is zero, the right operand is the whole word, and its C field is treated as the discard address. The select has no effect in the cycle in which it is raised.
- R7: When a command's A address equals its C address and that address is a general register, the read returns the value being written in the same cycle.
- R8: While `reject` is high, the pipeline and the immediate select hold. `mem_data` and `mem_oe` stay unchanged, no register or front-end write takes place, and the commands presented in those cycles are dropped.
- R9: A nonzero `fault_code` sets `fault_flag` in the next cycle. The flag then stays set until reset.
- R10: After reset, `mem_oe`, `fe_oe` and `fault_flag` are low, the immediate select is off, and the pipeline holds no operation that targets the memory bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 32 | Packed A/B/C addresses, or an immediate value |
| imm_next | input | 1 | Treat the next cycle's word as immediate right operand |
| to_mem | input | 1 | Send this command's result to the memory data bus |
| reject | input | 1 | Memory side not ready; freeze the pipeline |
| fault_code | input | 2 | Memory-side fault code, 0 means none |
| mem_data | output | 32 | Output-stage result toward memory |
| mem_oe | output | 1 | Output enable for `mem_data` |
| fe_data | output | 32 | Result routed to the front-end bus |
| fe_oe | output | 1 | One-cycle valid for `fe_data` |
| fe_sel | output | 4 | Window register index (C minus 240) |
| fault_flag | output | 1 | Sticky exception flag |

## Verification
The bench fills every general register with a distinct arithmetic pattern and reads each one back. It then sweeps OR pairs with junk in the top byte of the command word. A design with a wrong field position or a wrong latency shows a mixed-up or shifted word.

The write paths are probed at their edges. Address 0, the discard address and mid-range addresses are written and then checked for aliasing into the general registers, which catches index truncation. Each of the 16 window addresses is written to confirm that `fe_oe` lasts a single cycle and that the store is untouched. A same-cycle read and write of one address exposes a design that drops the forwarding path.

An immediate word whose fields look like live addresses is issued to confirm that the left operand and the C field are masked. The select is raised in the same cycle as a normal command to confirm it only acts one cycle later. A reject window is held across a read and a write; a design that leaks would show a changed output, a dropped write that took effect, or a stray `mem_oe` after release.

// File: rtl/eu_dp_pkg.sv
package eu_dp_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int GEN_REGS  = 128;
    localparam int WIN_BASE  = 240;
    localparam int JUNK_ADDR = 128;
    localparam int FAULT_W   = 2;

    // Decoded kind of a register address
    typedef enum logic [1:0] {
        RC_ZERO = 2'd0,
        RC_GEN  = 2'd1,
        RC_WIN  = 2'd2,
        RC_DROP = 2'd3
    } reg_class_e;

    function automatic reg_class_e classify(input int addr, input int ngen, input int wbase);
        if (addr == 0)          return RC_ZERO;
        else if (addr < ngen)   return RC_GEN;
        else if (addr >= wbase) return RC_WIN;
        else                    return RC_DROP;
    endfunction

    function automatic logic [DATA_W-1:0] alu_or(input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r);
        return l | r;
    endfunction

endpackage

// File: rtl/eu_cmd_unpack.sv
module eu_cmd_unpack #(
    parameter int DW   = 32,
    parameter int AW   = 8,
    parameter int JUNK = 128
) (
    input  logic [DW-1:0] cmd_word,
    input  logic          imm_mode,
    output logic [AW-1:0] rd_a,
    output logic [AW-1:0] rd_b,
    output logic [AW-1:0] wr_c,
    output logic [DW-1:0] imm_data
);
    localparam int FIELDS = 3;

    logic [FIELDS-1:0][AW-1:0] fld;
    assign fld = cmd_word[FIELDS*AW-1:0];

    // In an immediate cycle the word is data: mask reads to zero and drop the write.
    always_comb begin
        if (imm_mode) begin
            rd_a = '0;
            rd_b = '0;
            wr_c = AW'(JUNK);
        end else begin
            rd_a = fld[0];
            rd_b = fld[1];
            wr_c = fld[2];
        end
    end

    assign imm_data = cmd_word;

endmodule

// File: rtl/eu_regbank.sv
module eu_regbank
    import eu_dp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int NGEN  = 128,
    parameter int WBASE = 240
) (
    input  logic                  clk,
    input  logic                  wr_allow,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic [1:0][AW-1:0]    rd_addr,
    output logic [1:0][DW-1:0]    rd_data
);
    localparam int IDX_W = $clog2(NGEN);
    localparam int PORTS = 2;

    logic [DW-1:0] cells [NGEN];
    logic          do_write;

    assign do_write = wr_allow && (classify(int'(wr_addr), NGEN, WBASE) == RC_GEN);

    always_ff @(posedge clk) begin
        if (do_write) begin
            cells[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic is_gen;
        logic fwd;
        assign is_gen = (classify(int'(rd_addr[p]), NGEN, WBASE) == RC_GEN);
        assign fwd    = do_write && (wr_addr == rd_addr[p]);
        assign rd_data[p] = !is_gen ? '0 :
                            fwd     ? wr_data :
                                      cells[rd_addr[p][IDX_W-1:0]];
    end

endmodule

// File: rtl/eu_fe_port.sv
module eu_fe_port
    import eu_dp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int NGEN  = 128,
    parameter int WBASE = 240
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic                fe_oe,
    output logic [$clog2((1<<AW)-WBASE)-1:0] fe_sel,
    output logic [DW-1:0]       fe_data
);
    localparam int SEL_W = $clog2((1 << AW) - WBASE);

    logic hit;
    assign hit = advance && (classify(int'(wr_addr), NGEN, WBASE) == RC_WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            fe_oe   <= 1'b0;
            fe_sel  <= '0;
            fe_data <= '0;
        end else begin
            fe_oe <= hit;
            if (hit) begin
                fe_data <= wr_data;
                fe_sel  <= SEL_W'(wr_addr - AW'(WBASE));
            end
        end
    end

endmodule

// File: rtl/eu_regpipe.sv
module eu_regpipe
    import eu_dp_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int NGEN  = GEN_REGS,
    parameter int WBASE = WIN_BASE,
    parameter int JUNK  = JUNK_ADDR,
    parameter int FW    = FAULT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] cmd_word,
    input  logic          imm_next,
    input  logic          to_mem,
    input  logic          reject,
    input  logic [FW-1:0] fault_code,
    output logic [DW-1:0] mem_data,
    output logic          mem_oe,
    output logic [DW-1:0] fe_data,
    output logic          fe_oe,
    output logic [$clog2((1<<AW)-WBASE)-1:0] fe_sel,
    output logic          fault_flag
);
    localparam int SEL_W = $clog2((1 << AW) - WBASE);

    typedef struct packed {
        logic          to_mem;
        logic [DW-1:0] left;
        logic [DW-1:0] right;
    } opnd_stage_t;

    typedef struct packed {
        logic          to_mem;
        logic [DW-1:0] value;
    } res_stage_t;

    logic              imm_q;
    logic [AW-1:0]     rd_a, rd_b, wr_c;
    logic [DW-1:0]     imm_data;
    logic [1:0][AW-1:0] rd_addr;
    logic [1:0][DW-1:0] rd_data;
    opnd_stage_t       s1_q, s1_d;
    res_stage_t        s2_q, s2_d;
    logic              advance;

    assign advance = !reject;

    eu_cmd_unpack #(.DW(DW), .AW(AW), .JUNK(JUNK)) u_unpack (
        .cmd_word (cmd_word),
        .imm_mode (imm_q),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .wr_c     (wr_c),
        .imm_data (imm_data)
    );

    assign rd_addr[0] = rd_a;
    assign rd_addr[1] = rd_b;

    eu_regbank #(.DW(DW), .AW(AW), .NGEN(NGEN), .WBASE(WBASE)) u_bank (
        .clk      (clk),
        .wr_allow (advance),
        .wr_addr  (wr_c),
        .wr_data  (s2_q.value),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    eu_fe_port #(.DW(DW), .AW(AW), .NGEN(NGEN), .WBASE(WBASE)) u_fe (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .wr_addr (wr_c),
        .wr_data (s2_q.value),
        .fe_oe   (fe_oe),
        .fe_sel  (fe_sel),
        .fe_data (fe_data)
    );

    // Operand capture and ALU stage inputs
    always_comb begin
        s1_d.to_mem = to_mem;
        s1_d.left   = rd_data[0];
        s1_d.right  = imm_q ? imm_data : rd_data[1];
        s2_d.to_mem = s1_q.to_mem;
        s2_d.value  = alu_or(s1_q.left, s1_q.right);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imm_q <= 1'b0;
            s1_q  <= '0;
            s2_q  <= '0;
        end else if (advance) begin
            imm_q <= imm_next;
            s1_q  <= s1_d;
            s2_q  <= s2_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_flag <= 1'b0;
        end else if (fault_code != '0) begin
            fault_flag <= 1'b1;
        end
    end

    assign mem_data = s2_q.value;
    assign mem_oe   = s2_q.to_mem;

endmodule

// File: rtl/eu_regpipe_checker.sv
module eu_regpipe_checker #(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int WBASE = 240,
    parameter int FW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] c_fld,
    input logic          imm_q,
    input logic          to_mem,
    input logic          reject,
    input logic [FW-1:0] fault_code,
    input logic [DW-1:0] mem_data,
    input logic          mem_oe,
    input logic          fe_oe,
    input logic          fault_flag
);
    logic win_hit;
    assign win_hit = (int'(c_fld) >= WBASE);

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_oe && !fe_oe && !fault_flag));

    p_mem_latency_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(to_mem && !reject && !rst, 2) && $past(!reject && !rst)) |-> mem_oe);

    p_reject_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $past(reject && !rst) |-> ($stable(mem_data) && $stable(mem_oe)));

    p_fault_set_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_code != '0) |=> fault_flag);

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        fault_flag |=> fault_flag);

    p_window_to_fe_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !reject && !imm_q && win_hit) |-> fe_oe);

    p_fe_source_r5: assert property (@(posedge clk) disable iff (rst)
        fe_oe |-> $past(!reject && !imm_q && win_hit));

endmodule

bind eu_regpipe eu_regpipe_checker #(.DW(DW), .AW(AW), .WBASE(WBASE), .FW(FW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .c_fld      (cmd_word[3*AW-1:2*AW]),
    .imm_q      (imm_q),
    .to_mem     (to_mem),
    .reject     (reject),
    .fault_code (fault_code),
    .mem_data   (mem_data),
    .mem_oe     (mem_oe),
    .fe_oe      (fe_oe),
    .fault_flag (fault_flag)
);

// File: tb/eu_regpipe_bench.sv
module eu_regpipe_bench;

    localparam logic [7:0] JUNK = 8'd128;
    localparam int WATCHDOG = 60000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cmd_word;
    logic        imm_next, to_mem, reject;
    logic [1:0]  fault_code;
    logic [31:0] mem_data, fe_data;
    logic        mem_oe, fe_oe, fault_flag;
    logic [3:0]  fe_sel;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [31:0] model [128];

    always #4 clk = ~clk;

    eu_regpipe u_eu_regpipe (
        .clk(clk), .rst(rst), .cmd_word(cmd_word), .imm_next(imm_next),
        .to_mem(to_mem), .reject(reject), .fault_code(fault_code),
        .mem_data(mem_data), .mem_oe(mem_oe), .fe_data(fe_data),
        .fe_oe(fe_oe), .fe_sel(fe_sel), .fault_flag(fault_flag)
    );

    function automatic logic [31:0] pack3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        return {8'h00, c, b, a};
    endfunction

    function automatic logic [31:0] pat(input int i);
        logic [31:0] x;
        x = 32'(i) * 32'h9E37_79B9;
        return x ^ (32'(i) << 20) ^ 32'h0000_0101;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] w, input logic im, input logic tm,
                        input logic rj, input logic [1:0] fc);
        cmd_word   = w;
        imm_next   = im;
        to_mem     = tm;
        reject     = rj;
        fault_code = fc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();
        step(pack3(0, 0, JUNK), 0, 0, 0, 0);
    endtask

    // Load a value through the immediate path; returns in the cycle after the C step.
    task automatic write_reg(input logic [7:0] a, input logic [31:0] v);
        step(pack3(0, 0, JUNK), 1, 0, 0, 0);
        step(v, 0, 0, 0, 0);
        nop();
        step(pack3(0, 0, a), 0, 0, 0, 0);
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] b, input logic [31:0] exp, input string req);
        step(pack3(a, b, JUNK), 0, 1, 0, 0);
        nop();
        check(req, {31'b0, mem_oe}, 32'd1);
        check(req, mem_data, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cmd_word = pack3(0, 0, JUNK);
        imm_next = 0; to_mem = 0; reject = 0; fault_code = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        check("R10 mem_oe", {31'b0, mem_oe}, 32'd0);
        check("R10 fe_oe", {31'b0, fe_oe}, 32'd0);
        check("R10 fault_flag", {31'b0, fault_flag}, 32'd0);
        step(pack3(0, 0, JUNK), 0, 0, 0, 0);
        check("R10 no stray mem_oe", {31'b0, mem_oe}, 32'd0);
        // R10: immediate select off after reset, so a plain read is a read
        read_chk(8'd0, 8'd0, 32'd0, "R10 plain read after reset");

        // R3: fill every general register, no front-end activity
        model[0] = '0;
        for (int i = 1; i < 128; i++) begin
            model[i] = pat(i);
            write_reg(8'(i), pat(i));
            check("R3 no fe_oe on general write", {31'b0, fe_oe}, 32'd0);
        end
        for (int i = 1; i < 128; i++) begin
            read_chk(8'(i), 8'd0, model[i], "R3 readback");
        end

        // R1/R2: OR pairs with junk in the top byte
        for (int i = 1; i < 128; i++) begin
            int j;
            j = (i * 37) % 127 + 1;
            step(pack3(8'(i), 8'(j), JUNK) | 32'hA500_0000, 0, 1, 0, 0);
            nop();
            check("R2 mem_oe at N+2", {31'b0, mem_oe}, 32'd1);
            check("R1 R2 OR of ports", mem_data, model[i] | model[j]);
        end

        // R4: address 0, discard and mid range
        write_reg(8'd0, 32'hFFFF_FFFF);
        read_chk(8'd0, 8'd0, 32'd0, "R4 addr0 reads zero");
        write_reg(JUNK, 32'h1234_5678);
        read_chk(JUNK, 8'd0, 32'd0, "R4 junk reads zero");
        write_reg(8'd200, 32'h8765_4321);
        read_chk(8'd200, 8'd0, 32'd0, "R4 mid range reads zero");
        read_chk(8'd72, 8'd0, model[72], "R4 no alias of 200");
        read_chk(8'd0, 8'd0, 32'd0, "R4 no alias of 128");

        // R5: window sweep
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v;
            v = 32'hF00D_0000 | 32'(k * 4099);
            write_reg(8'(240 + k), v);
            check("R5 fe_oe", {31'b0, fe_oe}, 32'd1);
            check("R5 fe_data", fe_data, v);
            check("R5 fe_sel", {28'b0, fe_sel}, 32'(k));
            nop();
            check("R5 fe_oe one cycle", {31'b0, fe_oe}, 32'd0);
            read_chk(8'(240 + k), 8'd0, 32'd0, "R5 window reads zero");
            read_chk(8'(112 + k), 8'd0, model[112 + k], "R5 no alias into store");
        end

        // R6: immediate masks A and C fields
        step(pack3(0, 0, JUNK), 1, 0, 0, 0);
        step({8'h3C, 8'd7, 8'd9, 8'd5}, 0, 1, 0, 0);
        nop();
        check("R6 immediate passes whole word", mem_data, {8'h3C, 8'd7, 8'd9, 8'd5});
        nop();
        read_chk(8'd7, 8'd0, model[7], "R6 immediate C field ignored");
        // R6: select does not act in the cycle it is raised
        step(pack3(8'd3, 8'd4, JUNK), 1, 1, 0, 0);
        step(pack3(0, 0, JUNK), 0, 0, 0, 0);
        check("R6 same-cycle select ignored", mem_data, model[3] | model[4]);

        // R7: forwarding on same-cycle read and write
        step(pack3(0, 0, JUNK), 1, 0, 0, 0);
        step(32'hC0FF_EE11, 0, 0, 0, 0);
        nop();
        step(pack3(8'd10, 8'd0, 8'd10), 0, 1, 0, 0);
        nop();
        check("R7 forwarded value", mem_data, 32'hC0FF_EE11);
        model[10] = 32'hC0FF_EE11;
        read_chk(8'd10, 8'd0, model[10], "R7 stored value");

        // R8: reject holds, drops commands and writes
        step(pack3(8'd30, 8'd0, JUNK), 0, 1, 0, 0);
        nop();
        check("R8 pre-reject value", mem_data, model[30]);
        step(pack3(8'd31, 8'd0, 8'd20), 0, 1, 1, 0);
        check("R8 hold data", mem_data, model[30]);
        check("R8 hold oe", {31'b0, mem_oe}, 32'd1);
        step(pack3(8'd31, 8'd0, 8'd20), 0, 1, 1, 0);
        check("R8 hold data 2", mem_data, model[30]);
        nop();
        check("R8 rejected read dropped", {31'b0, mem_oe}, 32'd0);
        read_chk(8'd20, 8'd0, model[20], "R8 write suppressed");

        // R9: sticky fault flag
        check("R9 flag clear", {31'b0, fault_flag}, 32'd0);
        step(pack3(0, 0, JUNK), 0, 0, 0, 2'd2);
        check("R9 flag set", {31'b0, fault_flag}, 32'd1);
        nop(); nop(); nop();
        check("R9 flag sticky", {31'b0, fault_flag}, 32'd1);
        rst = 1;
        nop();
        rst = 0;
        check("R10 flag cleared by reset", {31'b0, fault_flag}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule